// File: doc/BRIEF.md
# Microprogrammed Control Sequencer with Conditional Branching

This block drives a single-bus processor datapath by reading one microinstruction per clock from an internal control store and presenting its control word as registered output strobes. A micro-address register selects the word. The same register is loaded from one of four places: its own value plus one, a starting address looked up from the instruction opcode, a branch target taken when a selected condition input is true, or a branch target taken unconditionally. A word marked as a memory wait freezes sequencing until the memory reports completion. A word marked as final sends sequencing back to the shared fetch routine at address 0.

Mutually exclusive signals are stored as binary codes and expanded by a decoder in the same cycle that the word is read. The bus-driver selection is a 3-bit code for none, PC, MDR, Z, R1 and R3. The ALU request is a 2-bit code for idle, add the constant 4, and add Y. The expanded strobes are registered together with the sequencing fields.

The sequencer is a three-state machine. BOOT is held during reset and takes one cycle after it. On the BOOT->RUN transition it fetches word 0. RUN->STALL happens when a wait word sees memory completion low. STALL->STALL holds the word. STALL->RUN or RUN->RUN happens on completion or for any other word. The control store holds these routines:
- fetch at 0..3, with a dispatch word at 3;
- memory-operand add (R1 <- R1 + mem[R3]) at 0x10;
- register add (R1 <- R1 + R3) at 0x20;
- two conditional tests at 0x30 and 0x34, with a shared taken target at 0x38;
- an unconditional jump at 0x40 to 0x48.

Top module: `micro_ctrl`

## Requirements
- R1: While reset is low, `upc` is 0 and every strobe output is 0. The first rising edge after release presents word 0.
- R2: Fetch steps through addresses 0, 1, 2, 3 in that order. The strobes are: word 0 = pc_out, mar_in, mem_rd, alu_add, z_in; word 1 = z_out, pc_in, y_in, wait_mem; word 2 = mdr_out, ir_in; word 3 = none (dispatch).
- R3: While the presented word has wait_mem set and mem_done is low, `upc` and all strobes hold. The edge after mem_done is seen high moves on to the next word.
- R4: The dispatch word loads `upc` from the opcode map: 0 -> 0x10, 1 -> 0x20, 2 -> 0x30, 3 -> 0x40, 4 -> 0x34. Any other opcode maps to 0.
- R5: The conditional word at 0x30 tests cond_in[0], and the one at 0x34 tests cond_in[3]. If the tested bit is 1 the next address is 0x38 (z_out, pc_in, end_step); if it is 0 the next address is the word's address plus one. Word 0x31 is r1_out, end_step and word 0x35 is r3_out, end_step. Untested bits have no effect.
- R6: The jump word at 0x40 (r3_out) always goes next to 0x48 (z_out, end_step), whatever the condition inputs are.
- R7: After a word with end_step set, the next address is 0.
- R8: At most one of pc_out, mdr_out, z_out, r1_out, r3_out is high in any cycle.
- R9: The memory-operand add runs 0x10 (r3_out, mar_in, mem_rd), 0x11 (r1_out, y_in, wait_mem), 0x12 (mdr_out, sel_y, alu_add, z_in), 0x13 (z_out, r1_in, end_step). The register add runs 0x20 (r3_out, y_in), 0x21 (r1_out, sel_y, alu_add, z_in), 0x22 (z_out, r1_in, end_step).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | OPC_W | Opcode field of the loaded instruction |
| cond_in | input | CC_W | Condition codes and external test inputs |
| mem_done | input | 1 | Memory operation complete |
| upc | output | 8 | Address of the presented microinstruction |
| pc_in | output | 1 | Load PC from bus |
| pc_out | output | 1 | PC drives bus |
| mar_in | output | 1 | Load MAR from bus |
| mem_rd | output | 1 | Start memory read |
| mdr_out | output | 1 | MDR drives bus |
| ir_in | output | 1 | Load IR from bus |
| y_in | output | 1 | Load Y from bus |
| sel_y | output | 1 | ALU A operand is Y (0 = constant 4) |
| alu_add | output | 1 | ALU adds |
| z_in | output | 1 | Load Z from ALU |
| z_out | output | 1 | Z drives bus |
| r1_out | output | 1 | R1 drives bus |
| r1_in | output | 1 | Load R1 from bus |
| r3_out | output | 1 | R3 drives bus |
| wait_mem | output | 1 | Presented word waits for memory |
| end_step | output | 1 | Presented word ends the routine |

## Verification
The hardest situations to reach from the ports are a wait that lasts several cycles in the middle of a routine, and a condition input that matters at exactly one edge. Both can only be reached by first walking the full fetch sequence and the dispatch. The bench runs every routine from a real fetch, keeps mem_done low for a chosen number of cycles on both wait words, and then raises it. For the branch tests it sets cond_in before the edge that leaves the test word. It also sets only the untested bit, to show that the bit is ignored.

// File: rtl/uctl_pkg.sv
package uctl_pkg;

    localparam int UA_W = 8;
    localparam int NSRC = 6;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_PC   = 3'd1,
        SRC_MDR  = 3'd2,
        SRC_Z    = 3'd3,
        SRC_R1   = 3'd4,
        SRC_R3   = 3'd5
    } src_e;

    typedef enum logic [1:0] {
        ALU_IDLE = 2'd0,
        ALU_ADD4 = 2'd1,
        ALU_ADDY = 2'd2
    } alu_e;

    typedef enum logic [1:0] {
        NX_INC  = 2'd0,
        NX_MAP  = 2'd1,
        NX_COND = 2'd2,
        NX_JUMP = 2'd3
    } nxt_e;

    typedef struct packed {
        src_e src;
        logic pc_in;
        logic mar_in;
        logic ir_in;
        logic y_in;
        logic z_in;
        logic r1_in;
        alu_e alu;
        logic rd;
    } dp_t;

    typedef struct packed {
        nxt_e            nxt;
        logic [1:0]      csel;
        logic [UA_W-1:0] tgt;
        logic            wmfc;
        logic            fin;
    } seq_t;

    typedef struct packed {
        dp_t  dp;
        seq_t sq;
    } uinstr_t;

    typedef struct packed {
        logic pc_in;
        logic pc_out;
        logic mar_in;
        logic rd;
        logic mdr_out;
        logic ir_in;
        logic y_in;
        logic sel_y;
        logic alu_add;
        logic z_in;
        logic z_out;
        logic r1_out;
        logic r1_in;
        logic r3_out;
        logic wait_mem;
        logic fin;
    } ctl_t;

    localparam logic [UA_W-1:0] A_FETCH  = 8'h00;
    localparam logic [UA_W-1:0] A_DISP   = 8'h03;
    localparam logic [UA_W-1:0] A_ADDIND = 8'h10;
    localparam logic [UA_W-1:0] A_ADDREG = 8'h20;
    localparam logic [UA_W-1:0] A_BRZ    = 8'h30;
    localparam logic [UA_W-1:0] A_BRX    = 8'h34;
    localparam logic [UA_W-1:0] A_TAKEN  = 8'h38;
    localparam logic [UA_W-1:0] A_JMP    = 8'h40;
    localparam logic [UA_W-1:0] A_JDST   = 8'h48;

    // starting-address generator
    function automatic logic [UA_W-1:0] start_addr(input logic [31:0] op);
        case (op)
            32'd0:   return A_ADDIND;
            32'd1:   return A_ADDREG;
            32'd2:   return A_BRZ;
            32'd3:   return A_JMP;
            32'd4:   return A_BRX;
            default: return A_FETCH;
        endcase
    endfunction

endpackage

// File: rtl/uctl_store.sv
module uctl_store
    import uctl_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uinstr_t         word
);

    always_comb begin
        word = '0;
        case (addr)
            // fetch routine
            8'h00: begin
                word.dp.src = SRC_PC; word.dp.mar_in = 1'b1; word.dp.rd = 1'b1;
                word.dp.alu = ALU_ADD4; word.dp.z_in = 1'b1;
            end
            8'h01: begin
                word.dp.src = SRC_Z; word.dp.pc_in = 1'b1; word.dp.y_in = 1'b1;
                word.sq.wmfc = 1'b1;
            end
            8'h02: begin
                word.dp.src = SRC_MDR; word.dp.ir_in = 1'b1;
            end
            8'h03: word.sq.nxt = NX_MAP;
            // R1 <- R1 + mem[R3]
            8'h10: begin
                word.dp.src = SRC_R3; word.dp.mar_in = 1'b1; word.dp.rd = 1'b1;
            end
            8'h11: begin
                word.dp.src = SRC_R1; word.dp.y_in = 1'b1; word.sq.wmfc = 1'b1;
            end
            8'h12: begin
                word.dp.src = SRC_MDR; word.dp.alu = ALU_ADDY; word.dp.z_in = 1'b1;
            end
            8'h13: begin
                word.dp.src = SRC_Z; word.dp.r1_in = 1'b1; word.sq.fin = 1'b1;
            end
            // R1 <- R1 + R3
            8'h20: begin
                word.dp.src = SRC_R3; word.dp.y_in = 1'b1;
            end
            8'h21: begin
                word.dp.src = SRC_R1; word.dp.alu = ALU_ADDY; word.dp.z_in = 1'b1;
            end
            8'h22: begin
                word.dp.src = SRC_Z; word.dp.r1_in = 1'b1; word.sq.fin = 1'b1;
            end
            // conditional tests
            8'h30: begin
                word.sq.nxt = NX_COND; word.sq.csel = 2'd0; word.sq.tgt = A_TAKEN;
            end
            8'h31: begin
                word.dp.src = SRC_R1; word.sq.fin = 1'b1;
            end
            8'h34: begin
                word.sq.nxt = NX_COND; word.sq.csel = 2'd3; word.sq.tgt = A_TAKEN;
            end
            8'h35: begin
                word.dp.src = SRC_R3; word.sq.fin = 1'b1;
            end
            8'h38: begin
                word.dp.src = SRC_Z; word.dp.pc_in = 1'b1; word.sq.fin = 1'b1;
            end
            // unconditional jump
            8'h40: begin
                word.dp.src = SRC_R3; word.sq.nxt = NX_JUMP; word.sq.tgt = A_JDST;
            end
            8'h41: begin
                word.dp.src = SRC_R1; word.sq.fin = 1'b1;
            end
            8'h48: begin
                word.dp.src = SRC_Z; word.sq.fin = 1'b1;
            end
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/uctl_decode.sv
module uctl_decode
    import uctl_pkg::*;
(
    input  dp_t  dp,
    input  logic wmfc,
    input  logic fin,
    output ctl_t ctl
);

    logic [NSRC-2:0] bus_en;

    for (genvar i = 1; i < NSRC; i++) begin : g_bus
        localparam logic [2:0] IDX = 3'(i);
        assign bus_en[i-1] = (dp.src == src_e'(IDX));
    end

    always_comb begin
        ctl          = '0;
        ctl.pc_out   = bus_en[0];
        ctl.mdr_out  = bus_en[1];
        ctl.z_out    = bus_en[2];
        ctl.r1_out   = bus_en[3];
        ctl.r3_out   = bus_en[4];
        ctl.pc_in    = dp.pc_in;
        ctl.mar_in   = dp.mar_in;
        ctl.ir_in    = dp.ir_in;
        ctl.y_in     = dp.y_in;
        ctl.z_in     = dp.z_in;
        ctl.r1_in    = dp.r1_in;
        ctl.rd       = dp.rd;
        ctl.sel_y    = (dp.alu == ALU_ADDY);
        ctl.alu_add  = (dp.alu != ALU_IDLE);
        ctl.wait_mem = wmfc;
        ctl.fin      = fin;
    end

endmodule

// File: rtl/uctl_next.sv
module uctl_next
    import uctl_pkg::*;
#(
    parameter int OPC_W = 4,
    parameter int CC_W  = 4
) (
    input  seq_t             sq,
    input  logic [UA_W-1:0]  upc,
    input  logic [OPC_W-1:0] opcode,
    input  logic [CC_W-1:0]  cond_in,
    input  logic             mem_done,
    output logic             hold,
    output logic [UA_W-1:0]  nxt_addr
);

    logic [UA_W-1:0] seq_addr;

    assign seq_addr = upc + UA_W'(1);
    assign hold     = sq.wmfc & ~mem_done;

    always_comb begin
        if (sq.fin) begin
            nxt_addr = A_FETCH;
        end else begin
            unique case (sq.nxt)
                NX_INC:  nxt_addr = seq_addr;
                NX_MAP:  nxt_addr = start_addr(32'(opcode));
                NX_COND: nxt_addr = cond_in[sq.csel] ? sq.tgt : seq_addr;
                NX_JUMP: nxt_addr = sq.tgt;
            endcase
        end
    end

endmodule

// File: rtl/micro_ctrl.sv
module micro_ctrl
    import uctl_pkg::*;
#(
    parameter int OPC_W = 4,
    parameter int CC_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic [CC_W-1:0]  cond_in,
    input  logic             mem_done,
    output logic [UA_W-1:0]  upc,
    output logic             pc_in,
    output logic             pc_out,
    output logic             mar_in,
    output logic             mem_rd,
    output logic             mdr_out,
    output logic             ir_in,
    output logic             y_in,
    output logic             sel_y,
    output logic             alu_add,
    output logic             z_in,
    output logic             z_out,
    output logic             r1_out,
    output logic             r1_in,
    output logic             r3_out,
    output logic             wait_mem,
    output logic             end_step
);

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2
    } state_e;

    state_e          state_q, state_n;
    logic [UA_W-1:0] upc_q, addr_n, nxt_addr;
    logic            hold;
    seq_t            sq_q;
    ctl_t            ctl_q, ctl_n;
    uinstr_t         rom_w;

    uctl_next #(.OPC_W(OPC_W), .CC_W(CC_W)) u_next (
        .sq       (sq_q),
        .upc      (upc_q),
        .opcode   (opcode),
        .cond_in  (cond_in),
        .mem_done (mem_done),
        .hold     (hold),
        .nxt_addr (nxt_addr)
    );

    uctl_store u_store (
        .addr (addr_n),
        .word (rom_w)
    );

    uctl_decode u_dec (
        .dp   (rom_w.dp),
        .wmfc (rom_w.sq.wmfc),
        .fin  (rom_w.sq.fin),
        .ctl  (ctl_n)
    );

    // transitions
    always_comb begin
        unique case (state_q)
            ST_BOOT: begin
                state_n = ST_RUN;
                addr_n  = A_FETCH;
            end
            ST_RUN, ST_STALL: begin
                state_n = hold ? ST_STALL : ST_RUN;
                addr_n  = hold ? upc_q : nxt_addr;
            end
            default: begin
                state_n = ST_BOOT;
                addr_n  = A_FETCH;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            upc_q   <= '0;
        end else begin
            state_q <= state_n;
            upc_q   <= addr_n;
        end
    end

    // registered control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q  <= '0;
            ctl_q <= '0;
        end else begin
            sq_q  <= rom_w.sq;
            ctl_q <= ctl_n;
        end
    end

    assign upc      = upc_q;
    assign pc_in    = ctl_q.pc_in;
    assign pc_out   = ctl_q.pc_out;
    assign mar_in   = ctl_q.mar_in;
    assign mem_rd   = ctl_q.rd;
    assign mdr_out  = ctl_q.mdr_out;
    assign ir_in    = ctl_q.ir_in;
    assign y_in     = ctl_q.y_in;
    assign sel_y    = ctl_q.sel_y;
    assign alu_add  = ctl_q.alu_add;
    assign z_in     = ctl_q.z_in;
    assign z_out    = ctl_q.z_out;
    assign r1_out   = ctl_q.r1_out;
    assign r1_in    = ctl_q.r1_in;
    assign r3_out   = ctl_q.r3_out;
    assign wait_mem = ctl_q.wait_mem;
    assign end_step = ctl_q.fin;

endmodule

// File: rtl/uctl_chk.sv
module uctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_done,
    input logic [7:0] upc,
    input logic       pc_out,
    input logic       mdr_out,
    input logic       z_out,
    input logic       r1_out,
    input logic       r3_out,
    input logic       mem_rd,
    input logic       wait_mem,
    input logic       end_step
);

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_out, mdr_out, z_out, r1_out, r3_out})); // R8

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_mem && !mem_done) |=> ($stable(upc) && wait_mem)); // R3

    AST_END_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (end_step && !wait_mem) |=> (upc == 8'h00)); // R7

    AST_FETCH_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && pc_out) |=> (upc == 8'h01)); // R2

    AST_DISPATCH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 8'h03) |=> (upc inside {8'h00, 8'h10, 8'h20, 8'h30, 8'h34, 8'h40})); // R4

endmodule

bind micro_ctrl uctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_done (mem_done),
    .upc      (upc),
    .pc_out   (pc_out),
    .mdr_out  (mdr_out),
    .z_out    (z_out),
    .r1_out   (r1_out),
    .r3_out   (r3_out),
    .mem_rd   (mem_rd),
    .wait_mem (wait_mem),
    .end_step (end_step)
);

// File: tb/test_micro_ctrl.sv
`timescale 1ns/1ps
module test_micro_ctrl;

    localparam logic [15:0] S_PCIN = 16'h8000, S_PCOUT = 16'h4000, S_MARIN = 16'h2000,
                            S_RD   = 16'h1000, S_MDROUT = 16'h0800, S_IRIN = 16'h0400,
                            S_YIN  = 16'h0200, S_SELY = 16'h0100, S_ADD = 16'h0080,
                            S_ZIN  = 16'h0040, S_ZOUT = 16'h0020, S_R1OUT = 16'h0010,
                            S_R1IN = 16'h0008, S_R3OUT = 16'h0004, S_WAIT = 16'h0002,
                            S_END  = 16'h0001;
    localparam logic [15:0] W0 = S_PCOUT | S_MARIN | S_RD | S_ADD | S_ZIN;
    localparam logic [15:0] W1 = S_ZOUT | S_PCIN | S_YIN | S_WAIT;
    localparam logic [15:0] W2 = S_MDROUT | S_IRIN;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opcode = '0;
    logic [3:0] cond_in = '0;
    logic       mem_done = 1'b0;
    logic [7:0] upc;
    logic pc_in, pc_out, mar_in, mem_rd, mdr_out, ir_in, y_in, sel_y, alu_add;
    logic z_in, z_out, r1_out, r1_in, r3_out, wait_mem, end_step;
    logic [15:0] obs;
    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    micro_ctrl i_micro_ctrl (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .cond_in(cond_in), .mem_done(mem_done),
        .upc(upc), .pc_in(pc_in), .pc_out(pc_out), .mar_in(mar_in), .mem_rd(mem_rd),
        .mdr_out(mdr_out), .ir_in(ir_in), .y_in(y_in), .sel_y(sel_y), .alu_add(alu_add),
        .z_in(z_in), .z_out(z_out), .r1_out(r1_out), .r1_in(r1_in), .r3_out(r3_out),
        .wait_mem(wait_mem), .end_step(end_step)
    );

    assign obs = {pc_in, pc_out, mar_in, mem_rd, mdr_out, ir_in, y_in, sel_y, alu_add,
                  z_in, z_out, r1_out, r1_in, r3_out, wait_mem, end_step};

    task automatic check(input string tag, input logic [7:0] eu, input logic [15:0] es);
        nchk++;
        if (upc !== eu || obs !== es) begin
            nfail++;
            $display("FAIL %s: upc=%h sig=%h expected upc=%h sig=%h", tag, upc, obs, eu, es);
        end
    endtask

    task automatic step(input string tag, input logic [7:0] eu, input logic [15:0] es);
        @(posedge clk);
        @(negedge clk);
        check(tag, eu, es);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 in reset", 8'h00, 16'h0000);
        rst_n = 1'b1;
        step("R1 first word after reset", 8'h00, W0);
    endtask

    // entered with word 0 presented; leaves dispatch word presented
    task automatic t_fetch(input logic [3:0] op, input int stalls);
        opcode   = op;
        mem_done = 1'b0;
        step("R2 fetch word 1", 8'h01, W1);
        for (int k = 0; k < stalls; k++) step("R3 hold on fetch wait", 8'h01, W1);
        mem_done = 1'b1;
        step("R3 release to word 2", 8'h02, W2);
        mem_done = 1'b0;
        step("R2 dispatch word", 8'h03, 16'h0000);
    endtask

    task automatic t_add_mem(input int stalls);
        t_fetch(4'd0, 0);
        step("R4 map opcode 0", 8'h10, S_R3OUT | S_MARIN | S_RD);
        step("R9 operand wait word", 8'h11, S_R1OUT | S_YIN | S_WAIT);
        for (int k = 0; k < stalls; k++) step("R3 hold in routine", 8'h11, S_R1OUT | S_YIN | S_WAIT);
        mem_done = 1'b1;
        step("R9 add word", 8'h12, S_MDROUT | S_SELY | S_ADD | S_ZIN);
        mem_done = 1'b0;
        step("R9 writeback word", 8'h13, S_ZOUT | S_R1IN | S_END);
        step("R7 return to fetch", 8'h00, W0);
    endtask

    task automatic t_add_reg();
        t_fetch(4'd1, 2);
        step("R4 map opcode 1", 8'h20, S_R3OUT | S_YIN);
        step("R9 reg add word", 8'h21, S_R1OUT | S_SELY | S_ADD | S_ZIN);
        step("R9 reg writeback", 8'h22, S_ZOUT | S_R1IN | S_END);
        step("R7 return to fetch", 8'h00, W0);
    endtask

    task automatic t_branch(input logic [3:0] op, input logic [3:0] cc, input bit taken);
        logic [7:0] sa;
        logic [15:0] fall;
        sa   = (op == 4'd2) ? 8'h30 : 8'h34;
        fall = (op == 4'd2) ? (S_R1OUT | S_END) : (S_R3OUT | S_END);
        t_fetch(op, 1);
        cond_in = cc;
        step("R4 map to test word", sa, 16'h0000);
        if (taken) step("R5 branch taken", 8'h38, S_ZOUT | S_PCIN | S_END);
        else       step("R5 branch not taken", sa + 8'h01, fall);
        cond_in = '0;
        step("R7 return to fetch", 8'h00, W0);
    endtask

    task automatic t_jump();
        t_fetch(4'd3, 0);
        cond_in = 4'h0;
        step("R4 map opcode 3", 8'h40, S_R3OUT);
        step("R6 unconditional jump", 8'h48, S_ZOUT | S_END);
        step("R7 return to fetch", 8'h00, W0);
    endtask

    task automatic t_unmapped();
        t_fetch(4'd9, 0);
        step("R4 unmapped opcode to fetch", 8'h00, W0);
    endtask

    initial begin
        t_reset();
        t_add_mem(0);
        t_add_mem(3);
        t_add_reg();
        t_branch(4'd2, 4'b0001, 1'b1);
        t_branch(4'd2, 4'b1000, 1'b0);
        t_branch(4'd4, 4'b1000, 1'b1);
        t_branch(4'd4, 4'b0111, 1'b0);
        t_jump();
        t_unmapped();
        t_reset();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule